// File: doc/BRIEF.md
# SPI Master with Per-Select Configuration

This block is a serial-peripheral-interface master for one chip clock domain. Software programs it through a small word-addressed register port. A control register enables, disables or resets the block. A mode register holds the master bit, a stored mode-fault-disable bit and a four-bit select field. Four configuration registers, one for each chip select, set the serial clock divider, the word length, the clock polarity and the clock phase. When software writes a word to the transmit register, the block shifts it out MSB first on `mosi_o`. At the same time it shifts a word in from `miso_i` into the receive register.

The select field is one-cold: a zero bit chooses that device. The configuration of the chosen device sets how each word is timed. While no word is in flight, the serial clock rests at the polarity of the chosen configuration, so the clock is already at its idle level when a select line falls. When a word finishes and another is waiting, the next word follows with no gap and the select line stays low.

Top module: `spi_cfg_master`

## Requirements
- R1: After reset the status register (word 2) reads tx-empty (bit 1) = 1 and rx-full (bit 0) = 0. The mode register (word 1) reads 0xF0. The control register (word 0) and every configuration register (words 8..11) read 0. All four select outputs are high.
- R2: A word starts only when three things hold: the block is enabled (control bit 0 set, bit 1 cleared), the master bit (mode bit 0) is 1, and a device is selected. Writing the transmit register (word 3) clears tx-empty until the word moves into the shifter.
- R3: Mode bits [7:4] are a one-cold select field, and the lowest zero bit n selects chip select n. The value 0xF selects nothing, and a pending word then waits with every select line high. At most one select line is ever low.
- R4: Configuration register 8+n applies to chip select n. Its fields are divider [7:0], length code [11:8] (word length = code + 8, and codes above 8 give 16 bits), polarity [12] and inverted phase [13].
- R5: Each SCK level lasts `div` input clocks, and a divider of 0 acts as 1. The select line stays low for div*(2*bits+1) clocks per word.
- R6: While no word is in flight, SCK sits at the polarity of the selected configuration (configuration 0 when nothing is selected). SCK does not move in the cycle a select line falls.
- R7: With inverted phase = 1, data is captured on the leading SCK edge and the first bit is set up before that edge. With inverted phase = 0, data changes on leading edges and is captured on trailing edges.
- R8: Bits go out MSB first. Transmit bits above the word length are ignored. The received word reads from word 4 in the low bits, with the upper bits zero.
- R9: Rx-full is set when a word completes and cleared by a read of the receive register.
- R10: If a word is pending when the current one ends and a device is selected, the next word starts in the same cycle and the select line stays low across both.
- R11: Writing control bit 7 returns every register to its R1 value, drops any pending word and disables the block.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Register access strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 4 | Register word index |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, same cycle |
| sck_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |
| cs_n_o | output | 4 | Active-low chip selects |

## Verification
On every cycle the assertions check five things: that no more than one select line is low, that the line chosen at a load goes low next, that SCK does not move as a select falls, that SCK is back at idle polarity when a word ends, and how the status flags respond to transmit writes, receive reads and word completion. Other behaviours need the bench's scenarios to show them. These are the exact select-low duration for each divider and length, the bit order and capture edge seen by an independent slave model, length masking on receive, back-to-back words, and holding a word while the block is disabled, the master bit is clear or the select field is 0xF.

// File: rtl/spi_cfg_pkg.sv
`timescale 1ns/1ps
package spi_cfg_pkg;
  localparam int CS_N    = 4;
  localparam int CS_IW   = $clog2(CS_N);
  localparam int DATA_W  = 16;
  localparam int DIV_W   = 8;
  localparam int LEN_W   = 4;
  localparam int MIN_LEN = 8;
  localparam int ADDR_W  = 4;
  localparam int BUS_W   = 32;

  localparam logic [ADDR_W-1:0] A_CTRL = 4'd0;
  localparam logic [ADDR_W-1:0] A_MODE = 4'd1;
  localparam logic [ADDR_W-1:0] A_STAT = 4'd2;
  localparam logic [ADDR_W-1:0] A_TXD  = 4'd3;
  localparam logic [ADDR_W-1:0] A_RXD  = 4'd4;
  localparam logic [ADDR_W-1:0] A_CFG  = 4'd8;

  localparam int CTRL_EN  = 0;
  localparam int CTRL_DIS = 1;
  localparam int CTRL_RST = 7;
  localparam int MODE_MST = 0;
  localparam int MODE_MFD = 1;
  localparam int MODE_SEL = 4;

  typedef struct packed {
    logic             ncpha;
    logic             cpol;
    logic [LEN_W-1:0] len_code;
    logic [DIV_W-1:0] div;
  } cs_cfg_t;

  localparam int CFG_W = $bits(cs_cfg_t);
endpackage

// File: rtl/spi_cfg_regs.sv
`timescale 1ns/1ps
module spi_cfg_regs
  import spi_cfg_pkg::*;
(
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   req_i,
  input  logic                   we_i,
  input  logic [ADDR_W-1:0]      addr_i,
  input  logic [BUS_W-1:0]       wdata_i,
  output logic [BUS_W-1:0]       rdata_o,
  output logic                   en_o,
  output logic                   master_o,
  output logic [CS_N-1:0]        psel_o,
  output cs_cfg_t [CS_N-1:0]     cfg_o,
  output logic [DATA_W-1:0]      tx_word_o,
  output logic                   tx_full_o,
  input  logic                   load_i,
  input  logic                   done_i,
  input  logic [DATA_W-1:0]      rx_word_i,
  output logic                   srst_o
);
  logic wr, rd, wr_txd, rd_rxd, cfg_hit;
  logic [CS_IW-1:0] cfg_idx;
  logic en_q, mst_q, mfd_q, tx_full_q, rx_full_q;
  logic [CS_N-1:0] psel_q;
  cs_cfg_t [CS_N-1:0] cfg_q;
  logic [DATA_W-1:0] tx_q, rx_q;
  logic unused_wdata;

  assign wr      = req_i & we_i;
  assign rd      = req_i & ~we_i;
  assign wr_txd  = wr && addr_i == A_TXD;
  assign rd_rxd  = rd && addr_i == A_RXD;
  assign srst_o  = wr && addr_i == A_CTRL && wdata_i[CTRL_RST];
  assign cfg_hit = addr_i >= A_CFG && addr_i < A_CFG + ADDR_W'(CS_N);
  assign cfg_idx = CS_IW'(addr_i - A_CFG);
  assign unused_wdata = ^wdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q <= 1'b0; mst_q <= 1'b0; mfd_q <= 1'b0; psel_q <= '1;
      cfg_q <= '0; tx_q <= '0; rx_q <= '0; tx_full_q <= 1'b0; rx_full_q <= 1'b0;
    end else if (srst_o) begin
      en_q <= 1'b0; mst_q <= 1'b0; mfd_q <= 1'b0; psel_q <= '1;
      cfg_q <= '0; tx_q <= '0; rx_q <= '0; tx_full_q <= 1'b0; rx_full_q <= 1'b0;
    end else begin
      if (wr && addr_i == A_CTRL) begin
        if (wdata_i[CTRL_DIS])     en_q <= 1'b0;
        else if (wdata_i[CTRL_EN]) en_q <= 1'b1;
      end
      if (wr && addr_i == A_MODE) begin
        mst_q  <= wdata_i[MODE_MST];
        mfd_q  <= wdata_i[MODE_MFD];
        psel_q <= wdata_i[MODE_SEL +: CS_N];
      end
      if (wr && cfg_hit) cfg_q[cfg_idx] <= cs_cfg_t'(wdata_i[CFG_W-1:0]);
      if (load_i) tx_full_q <= 1'b0;
      if (wr_txd) begin
        tx_q      <= wdata_i[DATA_W-1:0];
        tx_full_q <= 1'b1;
      end
      if (rd_rxd) rx_full_q <= 1'b0;
      if (done_i) begin
        rx_full_q <= 1'b1;
        rx_q      <= rx_word_i;
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      A_CTRL: rdata_o[CTRL_EN] = en_q;
      A_MODE: begin
        rdata_o[MODE_MST] = mst_q;
        rdata_o[MODE_MFD] = mfd_q;
        rdata_o[MODE_SEL +: CS_N] = psel_q;
      end
      A_STAT: rdata_o[1:0] = {~tx_full_q, rx_full_q};
      A_RXD:  rdata_o[DATA_W-1:0] = rx_q;
      default: if (cfg_hit) rdata_o[CFG_W-1:0] = cfg_q[cfg_idx];
    endcase
  end

  assign en_o      = en_q;
  assign master_o  = mst_q;
  assign psel_o    = psel_q;
  assign cfg_o     = cfg_q;
  assign tx_word_o = tx_q;
  assign tx_full_o = tx_full_q;

  a_r2_txd_write_fills: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_txd |=> tx_full_q);
  a_r9_read_clears_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_rxd && !done_i && !srst_o) |=> !rx_full_q);
  a_r9_done_sets_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && !srst_o) |=> rx_full_q);
endmodule

// File: rtl/spi_cfg_engine.sv
`timescale 1ns/1ps
module spi_cfg_engine
  import spi_cfg_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              srst_i,
  input  logic              start_i,
  input  cs_cfg_t           cfg_i,
  input  logic [CS_IW-1:0]  cs_idx_i,
  input  logic [DATA_W-1:0] tx_word_i,
  input  logic              miso_i,
  output logic              load_o,
  output logic              done_o,
  output logic              busy_o,
  output logic [CS_IW-1:0]  cs_idx_o,
  output logic [DATA_W-1:0] rx_word_o,
  output logic              sck_o,
  output logic              mosi_o
);
  localparam int BITS_W = $clog2(DATA_W + 1);
  localparam int EDGE_W = $clog2(2 * DATA_W + 1);

  logic busy_q, sck_q, cpol_q, ncpha_q;
  logic [DIV_W-1:0]  cnt_q, div_q, new_div;
  logic [EDGE_W-1:0] edge_q;
  logic [BITS_W-1:0] bits_q, new_bits;
  logic [CS_IW-1:0]  cs_q;
  logic [DATA_W-1:0] tx_sr, rx_sr;
  logic tick, last, lead, capture;

  assign new_div  = (cfg_i.div == '0) ? DIV_W'(1) : cfg_i.div;
  assign new_bits = (cfg_i.len_code > LEN_W'(DATA_W - MIN_LEN)) ? BITS_W'(DATA_W)
                  : BITS_W'(cfg_i.len_code) + BITS_W'(MIN_LEN);
  assign tick    = busy_q && cnt_q == '0;
  assign last    = edge_q == EDGE_W'({bits_q, 1'b0});
  assign done_o  = tick && last;
  assign load_o  = start_i && (!busy_q || done_o);
  assign lead    = ~edge_q[0];           // next edge index is odd -> leading
  assign capture = (lead == ncpha_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0; sck_q <= 1'b0; cpol_q <= 1'b0; ncpha_q <= 1'b0;
      cnt_q <= '0; div_q <= '0; edge_q <= '0; bits_q <= '0; cs_q <= '0;
      tx_sr <= '0; rx_sr <= '0;
    end else if (srst_i) begin
      busy_q <= 1'b0; sck_q <= 1'b0; cpol_q <= 1'b0; ncpha_q <= 1'b0;
      cnt_q <= '0; div_q <= '0; edge_q <= '0; bits_q <= '0; cs_q <= '0;
      tx_sr <= '0; rx_sr <= '0;
    end else if (load_o) begin
      busy_q  <= 1'b1;
      div_q   <= new_div;
      cnt_q   <= new_div - 1'b1;
      edge_q  <= '0;
      bits_q  <= new_bits;
      cpol_q  <= cfg_i.cpol;
      ncpha_q <= cfg_i.ncpha;
      sck_q   <= cfg_i.cpol;
      cs_q    <= cs_idx_i;
      tx_sr   <= tx_word_i << (BITS_W'(DATA_W) - new_bits);
      rx_sr   <= '0;
    end else if (done_o) begin
      busy_q <= 1'b0;
    end else if (tick) begin
      edge_q <= edge_q + 1'b1;
      sck_q  <= ~sck_q;
      cnt_q  <= div_q - 1'b1;
      if (capture) rx_sr <= {rx_sr[DATA_W-2:0], miso_i};
      else if (!(lead && edge_q == '0)) tx_sr <= tx_sr << 1;
    end else if (busy_q) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign busy_o    = busy_q;
  assign cs_idx_o  = cs_q;
  assign rx_word_o = rx_sr;
  assign sck_o     = sck_q;
  assign mosi_o    = tx_sr[DATA_W-1];

  a_r4_len_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> (bits_q >= BITS_W'(MIN_LEN) && bits_q <= BITS_W'(DATA_W)));
  a_r5_sck_idle_at_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> sck_q == cpol_q);
endmodule

// File: rtl/spi_cfg_master.sv
`timescale 1ns/1ps
module spi_cfg_master
  import spi_cfg_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BUS_W-1:0]  wdata_i,
  output logic [BUS_W-1:0]  rdata_o,
  output logic              sck_o,
  output logic              mosi_o,
  input  logic              miso_i,
  output logic [CS_N-1:0]   cs_n_o
);
  logic en, master, tx_full, load, done, busy, srst, start, sel_valid;
  logic eng_sck, eng_mosi;
  logic [CS_N-1:0]   psel;
  logic [CS_IW-1:0]  sel_idx, cur_idx;
  logic [DATA_W-1:0] tx_word, rx_word;
  cs_cfg_t [CS_N-1:0] cfg;
  cs_cfg_t cfg_sel;

  spi_cfg_regs u_regs (
    .clk_i, .rst_ni, .req_i, .we_i, .addr_i, .wdata_i, .rdata_o,
    .en_o(en), .master_o(master), .psel_o(psel), .cfg_o(cfg),
    .tx_word_o(tx_word), .tx_full_o(tx_full),
    .load_i(load), .done_i(done), .rx_word_i(rx_word), .srst_o(srst)
  );

  // one-cold select, lowest zero wins
  always_comb begin
    sel_idx   = '0;
    sel_valid = 1'b0;
    for (int i = CS_N - 1; i >= 0; i--) begin
      if (!psel[i]) begin
        sel_idx   = CS_IW'(i);
        sel_valid = 1'b1;
      end
    end
  end

  assign cfg_sel = cfg[sel_idx];
  assign start   = tx_full && en && master && sel_valid;

  spi_cfg_engine u_eng (
    .clk_i, .rst_ni, .srst_i(srst), .start_i(start), .cfg_i(cfg_sel),
    .cs_idx_i(sel_idx), .tx_word_i(tx_word), .miso_i,
    .load_o(load), .done_o(done), .busy_o(busy), .cs_idx_o(cur_idx),
    .rx_word_o(rx_word), .sck_o(eng_sck), .mosi_o(eng_mosi)
  );

  assign sck_o  = busy ? eng_sck : cfg_sel.cpol;
  assign mosi_o = busy & eng_mosi;

  for (genvar g = 0; g < CS_N; g++) begin : g_cs
    assign cs_n_o[g] = !(busy && cur_idx == CS_IW'(g));
  end

  a_r3_one_select_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(~cs_n_o));
  a_r3_cs_follows_select: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load && !srst) |=> !cs_n_o[$past(sel_idx)]);
  a_r6_sck_still_at_select: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(&cs_n_o) |-> sck_o == $past(sck_o));
endmodule

// File: tb/sim_spi_cfg_master.sv
`timescale 1ns/1ps
module sim_spi_cfg_master;
  logic clk = 1'b0, rst_ni = 1'b0;
  logic req = 1'b0, we = 1'b0;
  logic [3:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic sck, mosi, miso;
  logic [3:0] cs_n;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  spi_cfg_master u0 (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .sck_o(sck), .mosi_o(mosi),
    .miso_i(miso), .cs_n_o(cs_n)
  );
  assign miso = mosi;  // loopback

  // monitors: monotonic counters, tests use deltas
  int low_cnt [4];
  int fall_cnt [4];
  logic [3:0] cs_prev = 4'hF;
  initial for (int i = 0; i < 4; i++) begin low_cnt[i] = 0; fall_cnt[i] = 0; end
  always @(negedge clk) begin
    for (int i = 0; i < 4; i++) begin
      if (!cs_n[i]) low_cnt[i]++;
      if (cs_prev[i] && !cs_n[i]) fall_cnt[i]++;
    end
    cs_prev <= cs_n;
  end

  // independent slave: samples mosi on the capture edge of the expected mode
  logic exp_cpol = 1'b0, exp_ncpha = 1'b1;
  logic [15:0] slv_word = '0;
  always @(posedge sck or negedge sck) begin
    if (cs_n != 4'hF) begin
      if ((sck != exp_cpol) == exp_ncpha) slv_word <= {slv_word[14:0], mosi};
    end
  end

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog act=%0d exp=<150000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk); req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk); req = 1'b1; we = 1'b0; addr = a;
    #1 d = rdata;
    @(negedge clk); req = 1'b0;
  endtask

  task automatic wait_rx(input string tag);
    logic [31:0] s;
    int n = 0;
    do begin rd(4'd2, s); n++; end while (!s[0] && n < 20000);
    if (!s[0]) chk(tag, s, 32'h1);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // {cs[31:30], div[29:22], code[21:18], cpol[17], ncpha[16], data[15:0]}
  localparam logic [31:0] VEC [6] = '{
    {2'd0, 8'd2,   4'd0,  1'b0, 1'b1, 16'h00A5},
    {2'd1, 8'd0,   4'd8,  1'b1, 1'b0, 16'hBEEF},
    {2'd2, 8'd3,   4'd4,  1'b0, 1'b0, 16'h0ABC},
    {2'd3, 8'd1,   4'd15, 1'b1, 1'b1, 16'h1234},
    {2'd0, 8'd255, 4'd0,  1'b1, 1'b0, 16'hFF3C},
    {2'd2, 8'd4,   4'd7,  1'b0, 1'b1, 16'hFFFF}
  };

  initial begin
    logic [31:0] v, r;
    int b0 [4];
    int f0 [4];
    idle(3);
    rst_ni = 1'b1;
    idle(2);

    // R1 reset state
    rd(4'd2, r);  chk("R1 status", r, 32'h2);
    rd(4'd1, r);  chk("R1 mode", r, 32'hF0);
    rd(4'd0, r);  chk("R1 ctrl", r, 32'h0);
    rd(4'd9, r);  chk("R1 cfg1", r, 32'h0);
    rd(4'd4, r);  chk("R1 rxd", r, 32'h0);
    chk("R1 cs idle", {28'h0, cs_n}, 32'hF);

    wr(4'd0, 32'h1);
    for (int k = 0; k < 6; k++) begin
      int cs, dv, bits, len;
      logic [15:0] mask, expd;
      v    = VEC[k];
      cs   = int'(v[31:30]);
      dv   = (v[29:22] == 0) ? 1 : int'(v[29:22]);
      bits = (v[21:18] > 8) ? 16 : int'(v[21:18]) + 8;
      mask = 16'((32'h1 << bits) - 1);
      expd = v[15:0] & mask;
      len  = dv * (2 * bits + 1);
      wr(4'(8 + cs), {18'h0, v[16], v[17], v[21:18], v[29:22]});
      wr(4'd1, {24'h0, ~(4'h1 << cs), 4'h1});
      idle(2);
      chk($sformatf("R6 idle sck v%0d", k), {31'h0, sck}, {31'h0, v[17]});
      exp_cpol = v[17]; exp_ncpha = v[16];
      for (int i = 0; i < 4; i++) begin b0[i] = low_cnt[i]; f0[i] = fall_cnt[i]; end
      wr(4'd3, {16'h0, v[15:0]});
      wait_rx($sformatf("R9 rx_full v%0d", k));
      rd(4'd4, r);
      chk($sformatf("R8 rxd v%0d", k), r, {16'h0, expd});
      chk($sformatf("R7 slave word v%0d", k), {16'h0, slv_word & mask}, {16'h0, expd});
      chk($sformatf("R5 low cycles v%0d", k), low_cnt[cs] - b0[cs], len);
      chk($sformatf("R3 falls v%0d", k), fall_cnt[cs] - f0[cs], 1);
      for (int i = 0; i < 4; i++)
        if (i != cs) chk($sformatf("R3 other cs v%0d", k), low_cnt[i] - b0[i], 0);
    end

    // R3 select 0xF holds a pending word; R2 tx-empty stays low
    exp_cpol = 1'b1; exp_ncpha = 1'b1;
    wr(4'd1, 32'hF1);
    b0[3] = low_cnt[3];
    wr(4'd3, 32'h005A);
    idle(50);
    chk("R3 no select while 0xF", {28'h0, cs_n}, 32'hF);
    rd(4'd2, r); chk("R2 tx not empty while held", r & 32'h2, 32'h0);
    wr(4'd1, 32'h71);   // cs3, cfg3: div1, 16 bits
    wait_rx("R3 release");
    rd(4'd2, r); chk("R9 full before read", r & 32'h1, 32'h1);
    rd(4'd4, r); chk("R3 held word", r, 32'h005A);
    rd(4'd2, r); chk("R9 read clears full", r & 32'h1, 32'h0);
    chk("R5 div1 16 bits", low_cnt[3] - b0[3], 33);

    // R10 back-to-back on cs1
    wr(4'd9, {18'h0, 1'b1, 1'b0, 4'd0, 8'd1});
    wr(4'd1, 32'hD1);
    exp_cpol = 1'b0; exp_ncpha = 1'b1;
    b0[1] = low_cnt[1]; f0[1] = fall_cnt[1];
    wr(4'd3, 32'h11);
    begin
      int n = 0;
      do begin rd(4'd2, r); n++; end while (!r[1] && n < 100);
    end
    wr(4'd3, 32'h22);
    idle(100);
    chk("R10 one select fall", fall_cnt[1] - f0[1], 1);
    chk("R10 continuous low", low_cnt[1] - b0[1], 34);
    rd(4'd4, r); chk("R10 last word", r, 32'h22);

    // R2 disabled: no transfer
    wr(4'd0, 32'h2);
    b0[1] = low_cnt[1];
    wr(4'd3, 32'h33);
    idle(50);
    chk("R2 disabled no activity", low_cnt[1] - b0[1], 0);
    rd(4'd2, r); chk("R2 disabled word pending", r & 32'h2, 32'h0);
    wr(4'd0, 32'h1);
    wait_rx("R2 enable");
    rd(4'd4, r); chk("R2 after enable", r, 32'h33);

    // R2 master bit clear: no transfer
    wr(4'd1, 32'hD0);
    b0[1] = low_cnt[1];
    wr(4'd3, 32'h44);
    idle(50);
    chk("R2 master off no activity", low_cnt[1] - b0[1], 0);
    wr(4'd1, 32'hD1);
    wait_rx("R2 master on");
    rd(4'd4, r); chk("R2 master on word", r, 32'h44);

    // R3 several zeros: lowest wins (0x9 -> cs1)
    wr(4'd1, 32'h91);
    b0[1] = low_cnt[1]; b0[2] = low_cnt[2];
    wr(4'd3, 32'h55);
    wait_rx("R3 multi zero");
    chk("R3 lowest zero cs1", low_cnt[1] - b0[1], 17);
    chk("R3 cs2 untouched", low_cnt[2] - b0[2], 0);
    rd(4'd4, r);

    // R11 soft reset
    wr(4'd10, 32'h1FFF);
    wr(4'd1, 32'hF1);
    wr(4'd3, 32'h66);
    wr(4'd0, 32'h80);
    rd(4'd10, r); chk("R11 cfg cleared", r, 32'h0);
    rd(4'd1, r);  chk("R11 mode default", r, 32'hF0);
    rd(4'd2, r);  chk("R11 status default", r, 32'h2);
    rd(4'd0, r);  chk("R11 disabled", r, 32'h0);
    chk("R11 cs idle", {28'h0, cs_n}, 32'hF);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule